// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Sleep Wake-up

This block collects interrupt events into one flag bit per source. The sources are an external pin with a programmable edge, a four-bit input port watched for changes, and a parameterised set of synchronous peripheral event pulses. Each flag has its own enable bit, and a single global enable bit gates the request to the processor. Flags latch whenever their event occurs, whatever the global enable says. Software clears a flag by writing to the flag register; hardware never clears one.

The processor side is a small handshake. The block raises a request. An acceptance strobe drops the global enable so that no second interrupt nests. A return strobe raises the global enable again. While the processor reports that it is asleep, any source that is both flagged and enabled raises a wake-up output, even when the global enable is off. The global enable alone decides whether the processor then takes the vector, which is a fixed output of 0x004. A pending vector (flag AND enable) is exported so that software can poll it in fixed priority order, lowest index first.

Top module: `irq_ctrl_top`

## Requirements
- R1: A source's flag bit is set in the cycle after its event is detected, even when the global enable is 0.
- R2: `cpu_irq` is 1 exactly when the global enable is 1 and at least one source has both its flag bit and its enable bit at 1.
- R3: An acceptance strobe `cpu_ack` clears the global enable at the next clock edge. It takes precedence over a return strobe and over a control write made in the same cycle.
- R4: After reset, the flags, the enables, the global enable and the edge select are all 0, and `cpu_irq` and `wake` are 0.
- R5: A return strobe `cpu_reti` without `cpu_ack` sets the global enable at the next edge. It takes precedence over a control write made in the same cycle.
- R6: The external pin flags on a rising edge when the edge-select bit (address 2, bit 1) is 1, and on a falling edge when that bit is 0. An edge of the other polarity has no effect on the flag.
- R7: The register map is as follows. Address 0 holds the flags: bit 0 is the external pin, bit 1 is the port change, and bit 2+k is peripheral k. Address 1 holds the enables in the same layout. Address 2 is control: bit 0 is the global enable and bit 1 is the edge select. Address 3 reads 0. A write replaces the register's contents. Flags fall only through a write to address 0.
- R8: `wake` is 1 while `cpu_sleep` is 1 and any source is both flagged and enabled, whatever the global enable. `vector` always reads 0x004.
- R9: The port-change flag sets when the synchronised four-bit port differs from its previously latched value.
- R10: The pin and port inputs pass through a two-flop synchroniser. A change that is applied before clock edge k sets its flag at edge k+2 and is visible after that edge.
- R11: A write that clears a flag in the same cycle as a new event on that source leaves the flag set.
- R12: `pending` equals flags AND enables, so that polling from the lowest index picks the highest-priority active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_in | input | 4 | Asynchronous port watched for changes |
| periph_evt | input | N_PERIPH | Synchronous single-cycle peripheral events |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register (combinational) |
| cpu_ack | input | 1 | Processor accepts the interrupt |
| cpu_reti | input | 1 | Processor returns from the interrupt |
| cpu_sleep | input | 1 | Processor is asleep |
| cpu_irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |
| vector | output | VEC_W | Fixed interrupt vector address |
| pending | output | NSRC | Flag AND enable per source |

## Verification
The assertions check four things on every cycle. No flag falls unless address 0 is written. A detected event is latched at the next edge. The acceptance strobe leaves the global enable low and the request dropped in the following cycle. A lone return strobe leaves the global enable high. Other behaviours need the bench's scenarios and its cycle model to show them: the exact two-flop latency, edge polarity and its rejection of the opposite edge, the port comparison, the clear-versus-event collision, waking with the global enable off, and priority polling of the pending vector.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam int CTRL_GIE_BIT = 0;
  localparam int CTRL_EDGE_BIT = 1;
  localparam int SRC_EXT = 0;
  localparam int SRC_PORT = 1;
  localparam int SRC_PERIPH0 = 2;
endpackage

// File: rtl/irq_sync_detect.sv
module irq_sync_detect #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic              edge_rise,
  output logic              ext_evt,
  output logic              port_evt
);
  localparam int W = PORT_W + 1;

  logic [W-1:0] s1_q, s2_q, last_q;
  logic [W-1:0] s1_d, s2_d, last_d;

  always_comb begin
    s1_d   = {port_in, ext_pin};
    s2_d   = s1_q;
    last_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      last_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    if (edge_rise) ext_evt = s2_q[0] & ~last_q[0];
    else           ext_evt = ~s2_q[0] & last_q[0];
    port_evt = |(s2_q[W-1:1] ^ last_q[W-1:1]);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 6,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            wr_flags,
  input  logic            wr_enable,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] enables
);
  logic [NSRC-1:0] flag_d, en_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      flag_d[i] = (wr_flags ? wdata[i] : flags[i]) | evt[i];
      en_d[i]   = wr_enable ? wdata[i] : enables[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i]   <= 1'b0;
        enables[i] <= 1'b0;
      end else begin
        flags[i]   <= flag_d[i];
        enables[i] <= en_d[i];
      end
    end
  end

  // R7: hardware never lowers a flag
  a_r7_no_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> (($past(flags) & ~flags) == '0));

  // R1: detected events latch into their flag
  a_r1_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_global_ctrl.sv
module irq_global_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wgie,
  input  logic wedge,
  input  logic ack,
  input  logic reti,
  output logic gie,
  output logic edge_rise
);
  logic gie_d, edge_d;

  always_comb begin
    gie_d  = gie;
    edge_d = edge_rise;
    if (wr_ctrl) begin
      gie_d  = wgie;
      edge_d = wedge;
    end
    if (reti) gie_d = 1'b1;
    if (ack)  gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie       <= 1'b0;
      edge_rise <= 1'b0;
    end else begin
      gie       <= gie_d;
      edge_rise <= edge_d;
    end
  end

  // R3: acceptance leaves the global enable low
  a_r3_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !gie);

  // R5: a lone return strobe re-arms the global enable
  a_r5_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack) |=> gie);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int N_PERIPH = 4,
  parameter int PORT_W   = 4,
  parameter int DW       = 8,
  parameter int VEC_W    = 13,
  parameter logic [VEC_W-1:0] VEC_ADDR = 13'h004,
  localparam int NSRC    = SRC_PERIPH0 + N_PERIPH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_pin,
  input  logic [PORT_W-1:0]   port_in,
  input  logic [N_PERIPH-1:0] periph_evt,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic                cpu_ack,
  input  logic                cpu_reti,
  input  logic                cpu_sleep,
  output logic                cpu_irq,
  output logic                wake,
  output logic [VEC_W-1:0]    vector,
  output logic [NSRC-1:0]     pending
);
  logic ext_evt, port_evt, gie, edge_rise;
  logic [NSRC-1:0] evt, flags, enables;
  logic wr_flags, wr_enable, wr_ctrl;

  assign wr_flags  = reg_we && (reg_addr == ADDR_FLAGS);
  assign wr_enable = reg_we && (reg_addr == ADDR_ENABLE);
  assign wr_ctrl   = reg_we && (reg_addr == ADDR_CTRL);

  irq_sync_detect #(.PORT_W(PORT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
    .edge_rise(edge_rise), .ext_evt(ext_evt), .port_evt(port_evt)
  );

  assign evt = {periph_evt, port_evt, ext_evt};

  irq_flag_bank #(.NSRC(NSRC), .DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_flags(wr_flags),
    .wr_enable(wr_enable), .wdata(reg_wdata), .flags(flags), .enables(enables)
  );

  irq_global_ctrl u_gctl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .wgie(reg_wdata[CTRL_GIE_BIT]), .wedge(reg_wdata[CTRL_EDGE_BIT]),
    .ack(cpu_ack), .reti(cpu_reti), .gie(gie), .edge_rise(edge_rise)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_FLAGS:  reg_rdata[NSRC-1:0] = flags;
      ADDR_ENABLE: reg_rdata[NSRC-1:0] = enables;
      ADDR_CTRL: begin
        reg_rdata[CTRL_GIE_BIT]  = gie;
        reg_rdata[CTRL_EDGE_BIT] = edge_rise;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign pending = flags & enables;
  assign cpu_irq = gie & (|pending);
  assign wake    = cpu_sleep & (|pending);
  assign vector  = VEC_ADDR;

  // R2/R3: the request is gone in the cycle after acceptance
  a_r2_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_irq);
endmodule

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NS = 2 + NP;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_pin;
  logic [3:0] port_in;
  logic [NP-1:0] periph_evt;
  logic reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic cpu_ack, cpu_reti, cpu_sleep, cpu_irq, wake;
  logic [12:0] vector;
  logic [NS-1:0] pending;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl_top u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
    .periph_evt(periph_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_ack(cpu_ack),
    .cpu_reti(cpu_reti), .cpu_sleep(cpu_sleep), .cpu_irq(cpu_irq),
    .wake(wake), .vector(vector), .pending(pending)
  );

  // Bench cycle model built from the requirements
  logic [4:0] m_s1, m_s2, m_last;
  logic [NS-1:0] m_flags, m_en;
  logic m_gie, m_edge;

  function automatic logic [NS-1:0] model_evt();
    logic e;
    e = m_edge ? (m_s2[0] & ~m_last[0]) : (~m_s2[0] & m_last[0]);
    return {periph_evt, |(m_s2[4:1] ^ m_last[4:1]), e};
  endfunction

  function automatic logic [7:0] exp_rdata();
    case (reg_addr)
      2'd0: return {{(8-NS){1'b0}}, m_flags};
      2'd1: return {{(8-NS){1'b0}}, m_en};
      2'd2: return {6'b0, m_edge, m_gie};
      default: return 8'h00;
    endcase
  endfunction

  function automatic int first_set(logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_last <= '0;
      m_flags <= '0; m_en <= '0; m_gie <= 1'b0; m_edge <= 1'b0;
    end else begin
      logic g;
      m_s1 <= {port_in, ext_pin};
      m_s2 <= m_s1;
      m_last <= m_s2;
      m_flags <= ((reg_we && reg_addr == 2'd0) ? reg_wdata[NS-1:0] : m_flags) | model_evt();
      if (reg_we && reg_addr == 2'd1) m_en <= reg_wdata[NS-1:0];
      g = m_gie;
      if (reg_we && reg_addr == 2'd2) begin
        g = reg_wdata[0];
        m_edge <= reg_wdata[1];
      end
      if (cpu_reti) g = 1'b1;
      if (cpu_ack) g = 1'b0;
      m_gie <= g;
    end
  end

  task automatic chk(input string tag);
    logic [NS-1:0] ep;
    logic ei, ew;
    logic [7:0] er;
    ep = m_flags & m_en;
    ei = m_gie & (|ep);
    ew = cpu_sleep & (|ep);
    er = exp_rdata();
    n_chk++;
    if (pending !== ep || cpu_irq !== ei || wake !== ew || reg_rdata !== er ||
        vector !== 13'h004 || first_set(pending) != first_set(ep)) begin
      n_bad++;
      $display("FAIL %s: pend=%h irq=%b wake=%b rd=%h vec=%h exp pend=%h irq=%b wake=%b rd=%h vec=004",
               tag, pending, cpu_irq, wake, reg_rdata, vector, ep, ei, ew, er);
    end
  endtask

  task automatic idle();
    reg_we = 0; cpu_ack = 0; cpu_reti = 0; periph_evt = '0;
  endtask

  // drive in the low phase, check late in the cycle, then let the edge pass
  task automatic step(input string tag);
    #(CLK_PERIOD/4);
    chk(tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step(tag);
    idle();
  endtask

  task automatic wait_chk(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: expired, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; ext_pin = 0; port_in = '0; cpu_sleep = 0;
    reg_addr = 0; reg_wdata = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 reset state, each register read back
    for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); step("R4"); end

    // R1: peripheral flag latches with the global enable off
    periph_evt = 4'b0001; reg_addr = 0; step("R1"); idle();
    step("R1");
    // R12: enable several sources, check the pending vector and priority
    wr(2'd1, 8'h3F, "R12");
    periph_evt = 4'b1000; step("R12"); idle(); step("R12");
    // R2: the request rises with the global enable set
    wr(2'd2, 8'h01, "R2"); step("R2");
    // R3: ack together with reti and a control write
    cpu_ack = 1; cpu_reti = 1; reg_we = 1; reg_addr = 2; reg_wdata = 8'h01;
    step("R3"); idle(); reg_addr = 2; step("R3");
    // R5: return strobe alone
    cpu_reti = 1; step("R5"); idle(); step("R5");
    // R8: sleep wakes with the global enable off
    wr(2'd2, 8'h00, "R8"); cpu_sleep = 1; step("R8"); cpu_sleep = 0;
    // R7: clear flags by write, read back
    wr(2'd0, 8'h00, "R7"); reg_addr = 0; step("R7");
    // R6: falling edge only when edge select is 0
    ext_pin = 1; wait_chk(4, "R6");
    ext_pin = 0; wait_chk(4, "R6");
    // R6 rising with select 1; R10 latency of the synchroniser
    wr(2'd2, 8'h02, "R6"); wr(2'd0, 8'h00, "R6");
    ext_pin = 1; wait_chk(4, "R10");
    ext_pin = 0; wait_chk(4, "R6");
    // R9: port change
    wr(2'd0, 8'h00, "R9");
    port_in = 4'b0100; wait_chk(4, "R9");
    port_in = 4'b0101; wait_chk(4, "R9");
    // R11: clear collides with a new event
    reg_we = 1; reg_addr = 0; reg_wdata = 8'h00; periph_evt = 4'b0010;
    step("R11"); idle(); reg_addr = 0; step("R11");

    // random phase
    for (int c = 0; c < 3000; c++) begin
      if (($urandom % 8) == 0) ext_pin = ~ext_pin;
      if (($urandom % 8) == 0) port_in = 4'($urandom);
      periph_evt = (($urandom % 4) == 0) ? 4'($urandom) : '0;
      reg_we = (($urandom % 6) == 0);
      reg_addr = 2'($urandom);
      reg_wdata = 8'($urandom);
      cpu_ack = cpu_irq && (($urandom % 3) == 0);
      cpu_reti = (($urandom % 10) == 0);
      cpu_sleep = (($urandom % 5) == 0);
      step("RND");
    end
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule